// File: doc/BRIEF.md
# Doubleword Load/Store Interlock Scoreboard

This block sits at the issue stage of a pipelined core and decides when the next decoded instruction may start. It handles doubleword loads (one register pair written), doubleword stores (one register pair read), and plain ALU operations. It moves no data. For each load/store it sorts the addressing form into a one-issue or a two-issue shape and reports the issue count and the memory-cycle count. It keeps one countdown per architectural register for result readiness and a second one for write-after-read locks. An instruction is held at the input (`inReady` low, `stall` high) until the registers it needs early are ready, the registers it will write are unlocked, and the issue slot is free.

A counter loaded with latency L in the cycle an instruction is accepted (cycle t) keeps that register busy in cycles t+1 to t+L. A dependent instruction presented in cycle t+1 therefore waits exactly L cycles. The updated base of a load/store with writeback is the one exception: a load/store accepted immediately after the producer's last issue cycle may read it without waiting.

Top module: `dwsb_top`

## Requirements
- R1: Opcode 0 or 3 is an ALU op, 1 a doubleword load, 2 a doubleword store. A load/store is two-issue (`twoIssue`=1, `issueCycles`=2) when it uses a register offset (`inRegOffset`=1) that is negative, or whose shift is anything other than type 0 (left shift) with amount 0 or 2. Every other form, including all immediate offsets, is one-issue (`issueCycles`=1). ALU ops are one-issue.
- R2: `memCycles` is the issue count for an aligned load/store and the issue count plus one when `inAligned`=0. It is 0 for ALU ops.
- R3: A load makes Rd busy for 3 cycles (one-issue) or 4 cycles (two-issue). It makes Rd+1 (mod 16) busy for the same time when aligned, and one cycle longer when misaligned.
- R4: A store locks Rd for 1 cycle and Rd+1 for 2 cycles in a one-issue form, and for 2 and 3 cycles in a two-issue form. A later writer of a locked register is held. Readers of a store's registers are never held by the store.
- R5: A load/store with writeback makes Rn busy for 1 cycle. A load/store accepted in the cycle right after the producer's last issue cycle ignores that wait for its own base.
- R6: The registers checked for readiness are Rn and, if `inRegOffset`=1, Rm for ALU ops and one-issue forms. For two-issue forms only Rm is checked.
- R7: After a two-issue instruction is accepted, `inReady` is low for the following cycle.
- R8: `inReady` is low while any checked source is busy, any destination is locked, or a second issue cycle is in progress. `stall` equals `inValid` and not `inReady`. A held instruction is accepted, unchanged, in the first cycle these clear.
- R9: When a register counter is reloaded while still running, it keeps the larger of its decremented value and the new latency.
- R10: A synchronous active-high reset clears every counter, the issue-slot hold and the forward state, so `inReady` is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Instruction presented |
| inOp | input | 2 | Operation class: 0/3 ALU, 1 load, 2 store |
| inRd | input | 4 | Destination (load) or data source (store) register; pair partner is inRd+1 |
| inRn | input | 4 | Base register (ALU first source) |
| inRm | input | 4 | Offset register (ALU second source) |
| inRegOffset | input | 1 | 1 = register offset/operand used, 0 = immediate |
| inNegative | input | 1 | Offset is subtracted |
| inShiftType | input | 2 | 0 left, 1 logical right, 2 arithmetic right, 3 rotate |
| inShiftAmt | input | 5 | Shift amount of the offset register |
| inWriteback | input | 1 | Base register is updated |
| inAligned | input | 1 | Address is doubleword aligned |
| inReady | output | 1 | Instruction can be accepted this cycle |
| stall | output | 1 | Presented instruction is held |
| twoIssue | output | 1 | Presented form takes two issue cycles |
| issueCycles | output | 2 | Issue cycles of the presented instruction |
| memCycles | output | 2 | Memory cycles of the presented instruction |

## Verification
Two functions can land on the same register in one clock: the counter decrements and a fresh latency is loaded. The bench provokes this by sending a misaligned two-issue load and then a writeback load whose base is the pair's upper register. It judges the result by the number of cycles a reader of that register is held, which must match the longer pending wait and not the one-cycle base latency. The base-forward bypass can also meet a still-running counter. Random traffic confined to eight registers makes both cases frequent, and a bench model predicts the outcome cycle by cycle.

// File: rtl/dwsb_pkg.sv
package dwsb_pkg;
  parameter int NUM_REGS = 16;
  parameter int CNT_W = 3;
  parameter int SHAMT_W = 5;
  localparam int REG_W = $clog2(NUM_REGS);

  typedef enum logic [1:0] {OP_ALU = 2'd0, OP_LOAD = 2'd1, OP_STORE = 2'd2, OP_ALU2 = 2'd3} opT;
  typedef enum logic [1:0] {SH_LEFT = 2'd0, SH_LRIGHT = 2'd1, SH_ARIGHT = 2'd2, SH_ROT = 2'd3} shiftT;

  typedef logic [REG_W-1:0] regT;
  typedef logic [CNT_W-1:0] cntT;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic ldA;
    logic ldB;
    logic wbBase;
    logic stA;
    logic stB;
    regT  regA;
    regT  regB;
    regT  regBase;
    cntT  latA;
    cntT  latB;
    cntT  lockA;
    cntT  lockB;
  } strobeT;
endpackage

// File: rtl/dwsb_dp.sv
module dwsb_dp
  import dwsb_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  strobeT              strobe,
  output logic [NUM_REGS-1:0] notReady,
  output logic [NUM_REGS-1:0] locked
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : gReg
    cntT rdyCnt, lckCnt, rdyNext, lckNext;

    always_comb begin
      rdyNext = (rdyCnt == '0) ? '0 : rdyCnt - 1'b1;
      lckNext = (lckCnt == '0) ? '0 : lckCnt - 1'b1;
      if (strobe.ldA && strobe.regA == REG_W'(i) && strobe.latA > rdyNext) rdyNext = strobe.latA;
      if (strobe.ldB && strobe.regB == REG_W'(i) && strobe.latB > rdyNext) rdyNext = strobe.latB;
      if (strobe.wbBase && strobe.regBase == REG_W'(i) && CNT_W'(1) > rdyNext) rdyNext = CNT_W'(1);
      if (strobe.stA && strobe.regA == REG_W'(i) && strobe.lockA > lckNext) lckNext = strobe.lockA;
      if (strobe.stB && strobe.regB == REG_W'(i) && strobe.lockB > lckNext) lckNext = strobe.lockB;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        rdyCnt <= '0;
        lckCnt <= '0;
      end else begin
        rdyCnt <= rdyNext;
        lckCnt <= lckNext;
      end
    end

    assign notReady[i] = (rdyCnt != '0);
    assign locked[i]   = (lckCnt != '0);
  end
endmodule

// File: rtl/dwsb_ctrl.sv
module dwsb_ctrl
  import dwsb_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [1:0]          inOp,
  input  regT                 inRd,
  input  regT                 inRn,
  input  regT                 inRm,
  input  logic                inRegOffset,
  input  logic                inNegative,
  input  logic [1:0]          inShiftType,
  input  logic [SHAMT_W-1:0]  inShiftAmt,
  input  logic                inWriteback,
  input  logic                inAligned,
  input  logic [NUM_REGS-1:0] notReady,
  input  logic [NUM_REGS-1:0] locked,
  output logic                inReady,
  output logic                stall,
  output logic                twoIssue,
  output logic [1:0]          issueCycles,
  output logic [1:0]          memCycles,
  output strobeT              strobe
);
  logic isLoad, isStore, isLs, plainShift, twoForm;
  logic rnChecked, fwdHit, srcBusy, dstLocked, accept;
  logic busy, fwdOk;
  regT  fwdReg, pairReg;

  assign isLoad     = (inOp == OP_LOAD);
  assign isStore    = (inOp == OP_STORE);
  assign isLs       = isLoad || isStore;
  assign plainShift = (inShiftType == SH_LEFT) &&
                      (inShiftAmt == SHAMT_W'(0) || inShiftAmt == SHAMT_W'(2));
  assign twoForm    = isLs && inRegOffset && (inNegative || !plainShift);
  assign pairReg    = inRd + 1'b1;

  // Early source registers and destination lock checks
  assign rnChecked = !twoForm;
  assign fwdHit    = isLs && fwdOk && (fwdReg == inRn);
  assign srcBusy   = (rnChecked && notReady[inRn] && !fwdHit) ||
                     (inRegOffset && notReady[inRm]);
  assign dstLocked = (!isStore && locked[inRd]) ||
                     (isLoad && locked[pairReg]) ||
                     (isLs && inWriteback && locked[inRn]);

  assign inReady = !busy && !srcBusy && !dstLocked;
  assign stall   = inValid && !inReady;
  assign accept  = inValid && inReady;

  assign twoIssue    = twoForm;
  assign issueCycles = twoForm ? 2'd2 : 2'd1;
  assign memCycles   = isLs ? issueCycles + 2'(!inAligned) : 2'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      fwdOk  <= 1'b0;
      fwdReg <= '0;
    end else begin
      busy <= accept && twoForm;
      if (accept) begin
        fwdOk  <= isLs && inWriteback;
        fwdReg <= inRn;
      end else if (!busy) begin
        fwdOk <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.ldA     = accept && isLoad;
    strobe.ldB     = accept && isLoad;
    strobe.wbBase  = accept && isLs && inWriteback;
    strobe.stA     = accept && isStore;
    strobe.stB     = accept && isStore;
    strobe.regA    = inRd;
    strobe.regB    = pairReg;
    strobe.regBase = inRn;
    strobe.latA    = CNT_W'(3) + CNT_W'(twoForm);
    strobe.latB    = CNT_W'(3) + CNT_W'(twoForm) + CNT_W'(!inAligned);
    strobe.lockA   = CNT_W'(1) + CNT_W'(twoForm);
    strobe.lockB   = CNT_W'(2) + CNT_W'(twoForm);
  end
endmodule

// File: rtl/dwsb_top.sv
module dwsb_top
  import dwsb_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [1:0]         inOp,
  input  logic [REG_W-1:0]   inRd,
  input  logic [REG_W-1:0]   inRn,
  input  logic [REG_W-1:0]   inRm,
  input  logic               inRegOffset,
  input  logic               inNegative,
  input  logic [1:0]         inShiftType,
  input  logic [SHAMT_W-1:0] inShiftAmt,
  input  logic               inWriteback,
  input  logic               inAligned,
  output logic               inReady,
  output logic               stall,
  output logic               twoIssue,
  output logic [1:0]         issueCycles,
  output logic [1:0]         memCycles
);
  strobeT              strobe;
  logic [NUM_REGS-1:0] notReady;
  logic [NUM_REGS-1:0] locked;

  dwsb_ctrl uCtrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inOp(inOp), .inRd(inRd), .inRn(inRn),
    .inRm(inRm), .inRegOffset(inRegOffset), .inNegative(inNegative),
    .inShiftType(inShiftType), .inShiftAmt(inShiftAmt), .inWriteback(inWriteback),
    .inAligned(inAligned), .notReady(notReady), .locked(locked), .inReady(inReady),
    .stall(stall), .twoIssue(twoIssue), .issueCycles(issueCycles),
    .memCycles(memCycles), .strobe(strobe)
  );

  dwsb_dp uDp (
    .clk(clk), .rst(rst), .strobe(strobe), .notReady(notReady), .locked(locked)
  );
endmodule

// File: rtl/dwsb_chk.sv
module dwsb_chk
  import dwsb_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                inValid,
  input logic                inReady,
  input logic                stall,
  input logic                twoIssue,
  input strobeT              strobe,
  input logic [NUM_REGS-1:0] notReady,
  input logic [NUM_REGS-1:0] locked
);
  a_r7_second_slot_held: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && twoIssue) |=> !inReady);

  a_r3_load_pair_busy: assert property (@(posedge clk) disable iff (rst)
    (strobe.ldA && strobe.ldB) |=> (notReady[$past(strobe.regA)] && notReady[$past(strobe.regB)]));

  a_r4_store_pair_locked: assert property (@(posedge clk) disable iff (rst)
    strobe.stB |=> locked[$past(strobe.regB)]);

  a_r5_base_busy: assert property (@(posedge clk) disable iff (rst)
    strobe.wbBase |=> notReady[$past(strobe.regBase)]);

  a_r8_no_update_when_held: assert property (@(posedge clk) disable iff (rst)
    stall |-> !(strobe.ldA || strobe.stA || strobe.wbBase));

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (notReady == '0 && locked == '0 && inReady));
endmodule

bind dwsb_top dwsb_chk uChk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .stall(stall),
  .twoIssue(twoIssue), .strobe(strobe), .notReady(notReady), .locked(locked)
);

// File: tb/dwsb_top_test.sv
module dwsb_top_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tValid = 1'b0;
  logic [1:0] tOp = 2'd0;
  logic [3:0] tRd = 4'd0, tRn = 4'd0, tRm = 4'd0;
  logic tReg = 1'b0, tNeg = 1'b0, tWb = 1'b0, tAl = 1'b1;
  logic [1:0] tSht = 2'd0;
  logic [4:0] tSha = 5'd0;
  logic inReady, stall, twoIssue;
  logic [1:0] issueCycles, memCycles;

  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dwsb_top uut (
    .clk(clk), .rst(rst), .inValid(tValid), .inOp(tOp), .inRd(tRd), .inRn(tRn), .inRm(tRm),
    .inRegOffset(tReg), .inNegative(tNeg), .inShiftType(tSht), .inShiftAmt(tSha),
    .inWriteback(tWb), .inAligned(tAl), .inReady(inReady), .stall(stall),
    .twoIssue(twoIssue), .issueCycles(issueCycles), .memCycles(memCycles)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R8 watchdog expired: actual %0d cycles expected fewer than 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setFields(input int op, input int rd, input int rn, input int rm,
                           input bit rg, input bit ng, input int sht, input int sha,
                           input bit wb, input bit al);
    tOp = op[1:0]; tRd = rd[3:0]; tRn = rn[3:0]; tRm = rm[3:0];
    tReg = rg; tNeg = ng; tSht = sht[1:0]; tSha = sha[4:0]; tWb = wb; tAl = al;
  endtask

  // Present the fields already set; count held cycles until accepted
  task automatic send(output int held);
    @(negedge clk);
    tValid = 1'b1;
    held = 0;
    #1;
    while (!inReady) begin
      held++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 tValid = 1'b0;
  endtask

  task automatic idle(input int n);
    tValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; tValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Bench model state
  int mRdy[16], mLck[16];
  bit mBusy, mFwd;
  int mFwdReg;

  function automatic bit fLs();  return tOp == 2'd1 || tOp == 2'd2; endfunction
  function automatic bit fTwo();
    bit plain = (tSht == 2'd0) && (tSha == 5'd0 || tSha == 5'd2);
    return fLs() && tReg && (tNeg || !plain);
  endfunction
  function automatic bit fReady();
    bit src, dst;
    int pr = (int'(tRd) + 1) % 16;
    src = 0; dst = 0;
    if (!fTwo() && mRdy[tRn] > 0 && !(fLs() && mFwd && mFwdReg == int'(tRn))) src = 1;
    if (tReg && mRdy[tRm] > 0) src = 1;
    if (tOp != 2'd2 && mLck[tRd] > 0) dst = 1;
    if (tOp == 2'd1 && mLck[pr] > 0) dst = 1;
    if (fLs() && tWb && mLck[tRn] > 0) dst = 1;
    return !mBusy && !src && !dst;
  endfunction

  function automatic int imax(input int a, input int b); return a > b ? a : b; endfunction

  task automatic modelStep(input bit acc);
    int nr[16], nl[16];
    int two = fTwo();
    int pr = (int'(tRd) + 1) % 16;
    for (int r = 0; r < 16; r++) begin
      nr[r] = mRdy[r] > 0 ? mRdy[r] - 1 : 0;
      nl[r] = mLck[r] > 0 ? mLck[r] - 1 : 0;
    end
    if (acc) begin
      if (tOp == 2'd1) begin
        nr[tRd] = imax(nr[tRd], 3 + two);
        nr[pr]  = imax(nr[pr], 3 + two + (tAl ? 0 : 1));
      end
      if (fLs() && tWb) nr[tRn] = imax(nr[tRn], 1);
      if (tOp == 2'd2) begin
        nl[tRd] = imax(nl[tRd], 1 + two);
        nl[pr]  = imax(nl[pr], 2 + two);
      end
    end
    for (int r = 0; r < 16; r++) begin mRdy[r] = nr[r]; mLck[r] = nl[r]; end
    if (acc) begin mFwd = fLs() && tWb; mFwdReg = tRn; end
    else if (!mBusy) mFwd = 0;
    mBusy = acc && two;
  endtask

  initial begin
    int h;
    int rv;
    bit hold;
    void'($urandom(32'h5eed));
    doReset();

    // R10: reset state
    #1;
    chk("R10 inReady after reset", inReady, 1);
    chk("R10 stall after reset", stall, 0);

    // R1 and R2: classification (combinational, inValid low)
    setFields(1, 2, 1, 0, 0, 1, 0, 0, 0, 1); #1;
    chk("R1 immediate negative is one-issue", issueCycles, 1);
    setFields(1, 2, 1, 0, 1, 0, 0, 2, 0, 1); #1;
    chk("R1 reg shift left 2 is one-issue", twoIssue, 0);
    setFields(1, 2, 1, 0, 1, 0, 0, 3, 0, 1); #1;
    chk("R1 reg shift left 3 is two-issue", issueCycles, 2);
    setFields(2, 2, 1, 0, 1, 1, 0, 0, 0, 1); #1;
    chk("R1 negative reg offset is two-issue", issueCycles, 2);
    setFields(1, 2, 1, 0, 1, 0, 1, 0, 0, 1); #1;
    chk("R1 right shift is two-issue", twoIssue, 1);
    setFields(0, 2, 1, 0, 1, 1, 3, 7, 0, 1); #1;
    chk("R1 ALU is one-issue", issueCycles, 1);
    chk("R2 ALU has no memory cycles", memCycles, 0);
    setFields(1, 2, 1, 0, 0, 0, 0, 0, 0, 0); #1;
    chk("R2 misaligned one-issue", memCycles, 2);
    setFields(1, 2, 1, 0, 1, 1, 0, 0, 0, 0); #1;
    chk("R2 misaligned two-issue", memCycles, 3);
    setFields(2, 2, 1, 0, 1, 1, 0, 0, 0, 1); #1;
    chk("R2 aligned two-issue", memCycles, 2);

    // R3: load result latencies seen by an ALU reader
    setFields(1, 2, 9, 0, 0, 0, 0, 0, 0, 1); send(h);
    setFields(0, 15, 2, 0, 0, 0, 0, 0, 0, 1); send(h);
    chk("R3 aligned one-issue Rd", h, 3);
    idle(8);
    setFields(1, 2, 9, 0, 0, 0, 0, 0, 0, 0); send(h);
    setFields(0, 15, 3, 0, 0, 0, 0, 0, 0, 1); send(h);
    chk("R3 misaligned one-issue Rd+1", h, 4);
    idle(8);
    setFields(1, 2, 9, 0, 1, 1, 0, 0, 0, 0); send(h);
    setFields(0, 15, 3, 0, 0, 0, 0, 0, 0, 1); send(h);
    chk("R3 misaligned two-issue Rd+1", h, 5);
    idle(8);
    setFields(1, 2, 9, 0, 1, 1, 0, 0, 0, 1); send(h);
    setFields(0, 15, 2, 0, 0, 0, 0, 0, 0, 1); send(h);
    chk("R3 aligned two-issue Rd", h, 4);
    idle(8);

    // R4: store locks
    setFields(2, 4, 9, 0, 0, 0, 0, 0, 0, 1); send(h);
    setFields(0, 5, 1, 0, 0, 0, 0, 0, 0, 1); send(h);
    chk("R4 one-issue lock on Rd+1", h, 2);
    idle(8);
    setFields(2, 4, 9, 0, 0, 0, 0, 0, 0, 1); send(h);
    setFields(0, 4, 1, 0, 0, 0, 0, 0, 0, 1); send(h);
    chk("R4 one-issue lock on Rd", h, 1);
    idle(8);
    setFields(2, 4, 9, 0, 1, 1, 0, 0, 0, 1); send(h);
    setFields(0, 5, 1, 0, 0, 0, 0, 0, 0, 1); send(h);
    chk("R4 two-issue lock on Rd+1", h, 3);
    idle(8);
    setFields(2, 4, 9, 0, 0, 0, 0, 0, 0, 1); send(h);
    setFields(0, 15, 4, 5, 1, 0, 0, 0, 0, 1); send(h);
    chk("R4 store registers readable at once", h, 0);
    idle(8);

    // R5: base writeback latency and forwarding
    setFields(1, 0, 6, 0, 0, 0, 0, 0, 1, 1); send(h);
    setFields(0, 15, 6, 0, 0, 0, 0, 0, 0, 1); send(h);
    chk("R5 ALU waits for updated base", h, 1);
    idle(8);
    setFields(1, 0, 6, 0, 0, 0, 0, 0, 1, 1); send(h);
    setFields(1, 10, 6, 0, 0, 0, 0, 0, 0, 1); send(h);
    chk("R5 next load/store uses forwarded base", h, 0);
    idle(8);

    // R6: early registers per form
    setFields(1, 8, 9, 0, 0, 0, 0, 0, 0, 1); send(h);
    setFields(1, 10, 8, 0, 1, 1, 0, 0, 0, 1); send(h);
    chk("R6 two-issue form ignores busy Rn", h, 0);
    idle(8);
    setFields(1, 8, 9, 0, 0, 0, 0, 0, 0, 1); send(h);
    setFields(1, 10, 1, 8, 1, 0, 0, 0, 0, 1); send(h);
    chk("R6 one-issue form waits on Rm", h, 3);
    idle(8);

    // R7: second issue slot
    setFields(1, 10, 1, 0, 1, 1, 0, 0, 0, 1); send(h);
    setFields(0, 15, 5, 0, 0, 0, 0, 0, 0, 1); send(h);
    chk("R7 independent op held one cycle", h, 1);
    idle(8);

    // R8: held instruction reports stall
    setFields(1, 2, 9, 0, 0, 0, 0, 0, 0, 1); send(h);
    setFields(0, 15, 2, 0, 0, 0, 0, 0, 0, 1);
    @(negedge clk); tValid = 1'b1; #1;
    chk("R8 stall while source busy", stall, 1);
    chk("R8 inReady low while source busy", inReady, 0);
    idle(8);

    // R9: reload of a running counter keeps the larger value
    setFields(1, 12, 1, 0, 1, 1, 0, 0, 0, 0); send(h);
    setFields(1, 0, 13, 0, 1, 1, 0, 0, 1, 1); send(h);
    setFields(0, 15, 13, 0, 0, 0, 0, 0, 0, 1); send(h);
    chk("R9 longer pending wait kept", h, 3);
    idle(8);

    // Random phase against the bench model (R1 R2 R3 R4 R5 R6 R7 R8 R9)
    doReset();
    for (int r = 0; r < 16; r++) begin mRdy[r] = 0; mLck[r] = 0; end
    mBusy = 0; mFwd = 0; mFwdReg = 0;
    hold = 0;
    for (int n = 0; n < 4000; n++) begin
      bit expRdy;
      bit acc;
      @(negedge clk);
      if (!hold) begin
        rv = $urandom_range(0, 99);
        tValid = (rv < 75);
        setFields($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 7),
                  $urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 1),
                  ($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0,
                  $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 1));
      end
      #1;
      expRdy = fReady();
      chk("R8 random inReady", inReady, expRdy);
      chk("R8 random stall", stall, tValid && !expRdy);
      chk("R1 random issue count", issueCycles, fTwo() ? 2 : 1);
      chk("R2 random memory cycles", memCycles, fLs() ? (fTwo() ? 2 : 1) + (tAl ? 0 : 1) : 0);
      acc = tValid && expRdy;
      hold = tValid && !expRdy;
      @(posedge clk);
      modelStep(acc);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule